// File: doc/BRIEF.md
# Boot ROM Master Fetch Sequencer

This block loads its own configuration image by acting as the bus master of a byte-wide parallel ROM that it shares with a companion processor. A start pulse begins a load. The block then drives the ROM address and read enable, waits a fixed number of clocks for each access, and captures one byte. Each captured byte is presented on a stream output together with a running byte count. When the programmed number of bytes has been fetched, a tail of extra configuration clocks runs, and then the done flag rises.

The block holds the processor in reset for the whole load. It does this on two outputs of opposite polarity, so that a processor with either reset sense can be wired to it. A direction input, sampled at start, makes the fetch either ascend from address zero or descend from the top of the address space. The image can therefore sit at whichever end of the ROM the processor does not use for its reset vector and code. While idle or finished, the block withdraws its request to drive the address bus and leaves the ROM to the processor. The block does not interpret the bytes it fetches.

Top module: `boot_fetch_seq`

## Requirements
- R1: With the direction input low at start, the first read address is 0x0000 and the address rises by one after every captured byte.
- R2: With the direction input high at start, the first read address is 0xFFFF and the address falls by one after every captured byte.
- R3: The active-low hold output is low from the cycle after start until the done flag rises, and high while idle or done.
- R4: The active-high hold output is high over exactly the same cycles in which the active-low hold is low, and low otherwise.
- R5: Each read keeps the read enable high for WAIT_CYCLES clocks. The byte on the data input at the last of those clocks then appears on the byte output, with a one-cycle valid pulse.
- R6: The byte count starts at 0 on each load and rises by one with every valid pulse. The fetch phase ends after TOTAL_BYTES bytes.
- R7: After the last byte, the tail-clock output is high for exactly TAIL_CLKS cycles, at least 12. The done flag rises in the cycle after the last tail cycle.
- R8: While idle, in the tail or done, the read enable and the address-drive request are both low.
- R9: A start pulse in any state restarts the load in the next cycle: first address again, count 0, both holds asserted, done low.
- R10: After reset the block is idle. Both holds are released (active-low high, active-high low), done is low, the read enable is low and the count is 0.
- R11: The direction input is sampled only at start; changing it during a load does not change the address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin or restart a load |
| dir_down_i | input | 1 | 0: ascend from 0, 1: descend from top (sampled at start) |
| rom_data_i | input | 8 | ROM read data |
| rom_addr_o | output | ADDR_W | ROM address |
| rom_addr_oe_o | output | 1 | Request to drive the address bus |
| rom_rd_o | output | 1 | ROM read enable |
| hold_lo_n_o | output | 1 | Processor hold, low during load |
| hold_hi_o | output | 1 | Processor hold, high during load |
| tail_clk_o | output | 1 | Extra configuration clock enable |
| done_o | output | 1 | Load complete |
| byte_o | output | 8 | Last fetched byte |
| byte_valid_o | output | 1 | One-cycle pulse per fetched byte |
| byte_cnt_o | output | CNT_W | Bytes fetched in this load |

## Verification
The bench builds the block with TOTAL_BYTES of 8, WAIT_CYCLES of 3 and TAIL_CLKS of 12. With these values a complete load, including the tail and done, takes only 36 cycles. The bench can therefore trace every address step in both directions, every capture point inside a multi-cycle access, and the count rollover from 7 to the end of fetch. The short load also makes restarts in the middle of a fetch and from the done state cheap to reach. The top of the address space is reached directly through descending mode.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_TAIL = 2'd2,
    ST_DONE = 2'd3
  } bfs_state_e;
endpackage

// File: rtl/bfs_interval.sv
// Repeating interval counter: last_o marks the final cycle of a LIMIT-cycle window.
module bfs_interval #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic en_i,
  output logic last_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign last_o = en_i && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)     cnt_d = '0;
    else if (en_i)   cnt_d = last_o ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bfs_addr_gen.sv
// Address generator: loads the start address and latches direction at load, steps on each byte.
module bfs_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              dir_down_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              down_q, down_d;

  always_comb begin
    addr_d = addr_q;
    down_d = down_q;
    if (load_i) begin
      down_d = dir_down_i;
      addr_d = dir_down_i ? {ADDR_W{1'b1}} : '0;
    end else if (step_i) begin
      addr_d = down_q ? addr_q - ADDR_W'(1) : addr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      down_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      down_q <= down_d;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/boot_fetch_seq.sv
module boot_fetch_seq
  import bfs_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int TOTAL_BYTES = 256,
  parameter int WAIT_CYCLES = 3,
  parameter int TAIL_CLKS   = 12,
  localparam int CNT_W      = $clog2(TOTAL_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dir_down_i,
  input  logic [7:0]        rom_data_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              rom_addr_oe_o,
  output logic              rom_rd_o,
  output logic              hold_lo_n_o,
  output logic              hold_hi_o,
  output logic              tail_clk_o,
  output logic              done_o,
  output logic [7:0]        byte_o,
  output logic              byte_valid_o,
  output logic [CNT_W-1:0]  byte_cnt_o
);
  bfs_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       byte_q, byte_d;
  logic             valid_q, valid_d;
  logic             acc_last, tail_last, capture, last_byte;
  logic             in_load, in_tail;

  assign in_load   = (state_q == ST_LOAD);
  assign in_tail   = (state_q == ST_TAIL);
  assign capture   = in_load && acc_last && !start_i;
  assign last_byte = capture && (cnt_q == CNT_W'(TOTAL_BYTES - 1));

  bfs_interval #(.LIMIT(WAIT_CYCLES)) u_access (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_i || capture),
    .en_i    (in_load),
    .last_o  (acc_last)
  );

  bfs_interval #(.LIMIT(TAIL_CLKS)) u_tail (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (!in_tail),
    .en_i    (in_tail),
    .last_o  (tail_last)
  );

  bfs_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_i),
    .dir_down_i (dir_down_i),
    .step_i     (capture),
    .addr_o     (rom_addr_o)
  );

  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = ST_LOAD;
    end else begin
      case (state_q)
        ST_LOAD: if (last_byte) state_d = ST_TAIL;
        ST_TAIL: if (tail_last) state_d = ST_DONE;
        default: state_d = state_q;
      endcase
    end
  end

  always_comb begin
    cnt_d   = cnt_q;
    byte_d  = byte_q;
    valid_d = capture;
    if (start_i) begin
      cnt_d = '0;
    end else if (capture) begin
      cnt_d  = cnt_q + CNT_W'(1);
      byte_d = rom_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      byte_q  <= byte_d;
      valid_q <= valid_d;
    end
  end

  assign rom_rd_o      = in_load;
  assign rom_addr_oe_o = in_load;
  assign hold_hi_o     = in_load || in_tail;
  assign hold_lo_n_o   = !(in_load || in_tail);
  assign tail_clk_o    = in_tail;
  assign done_o        = (state_q == ST_DONE);
  assign byte_o        = byte_q;
  assign byte_valid_o  = valid_q;
  assign byte_cnt_o    = cnt_q;
endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic              rom_addr_oe_o,
  input logic              rom_rd_o,
  input logic              hold_lo_n_o,
  input logic              hold_hi_o,
  input logic              tail_clk_o,
  input logic              done_o,
  input logic              byte_valid_o,
  input logic [CNT_W-1:0]  byte_cnt_o
);
  a_r3_hold_lo_while_reading: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd_o |-> !hold_lo_n_o);

  a_r4_hold_hi_while_reading: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd_o |-> hold_hi_o);

  a_r5_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> $past(rom_rd_o));

  a_r6_count_nonzero_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> (byte_cnt_o != '0));

  a_r7_done_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(tail_clk_o));

  a_r8_no_read_without_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_addr_oe_o |-> !rom_rd_o);

  a_r9_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (hold_hi_o && !hold_lo_n_o && !done_o && rom_rd_o));

  a_r10_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (hold_lo_n_o && !hold_hi_o && !rom_rd_o && !tail_clk_o));
endmodule

bind boot_fetch_seq bfs_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bfs_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .rom_addr_o    (rom_addr_o),
  .rom_addr_oe_o (rom_addr_oe_o),
  .rom_rd_o      (rom_rd_o),
  .hold_lo_n_o   (hold_lo_n_o),
  .hold_hi_o     (hold_hi_o),
  .tail_clk_o    (tail_clk_o),
  .done_o        (done_o),
  .byte_valid_o  (byte_valid_o),
  .byte_cnt_o    (byte_cnt_o)
);

// File: tb/boot_fetch_seq_bench.sv
module boot_fetch_seq_bench;
  localparam int ADDR_W = 16;
  localparam int TOTAL  = 8;
  localparam int WAITC  = 3;
  localparam int TAIL   = 12;
  localparam int CNT_W  = $clog2(TOTAL + 1);
  localparam int LOADC  = TOTAL * WAITC;

  // vector: {flip_dir_mid_load, dir_down, expected first address}
  localparam logic [17:0] VEC [4] = '{
    {1'b0, 1'b0, 16'h0000},
    {1'b0, 1'b1, 16'hFFFF},
    {1'b1, 1'b0, 16'h0000},
    {1'b1, 1'b1, 16'hFFFF}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              dir_down_i = 1'b0;
  logic [7:0]        rom_data_i;
  logic [ADDR_W-1:0] rom_addr_o;
  logic              rom_addr_oe_o, rom_rd_o, hold_lo_n_o, hold_hi_o;
  logic              tail_clk_o, done_o, byte_valid_o;
  logic [7:0]        byte_o;
  logic [CNT_W-1:0]  byte_cnt_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rom_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign rom_data_i = rom_f(rom_addr_o);

  boot_fetch_seq #(
    .ADDR_W(ADDR_W), .TOTAL_BYTES(TOTAL), .WAIT_CYCLES(WAITC), .TAIL_CLKS(TAIL)
  ) u_boot_fetch_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_down_i(dir_down_i),
    .rom_data_i(rom_data_i), .rom_addr_o(rom_addr_o), .rom_addr_oe_o(rom_addr_oe_o),
    .rom_rd_o(rom_rd_o), .hold_lo_n_o(hold_lo_n_o), .hold_hi_o(hold_hi_o),
    .tail_clk_o(tail_clk_o), .done_o(done_o), .byte_o(byte_o),
    .byte_valid_o(byte_valid_o), .byte_cnt_o(byte_cnt_o)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_start(input logic dir);
    @(negedge clk);
    dir_down_i = dir;
    start_i    = 1'b1;
    @(negedge clk);
    start_i    = 1'b0;
  endtask

  // Runs a full load; the negedge right after the start edge is k = 1.
  task automatic run_load(input logic flip, input logic dir, input logic [15:0] first);
    int tail_seen = 0;
    pulse_start(dir);
    for (int k = 1; k <= LOADC + TAIL + 2; k++) begin
      if (k > 1) @(negedge clk);
      if (flip && k == 4) dir_down_i = ~dir;
      if (k <= LOADC) begin
        logic [15:0] ea;
        ea = dir ? first - 16'((k - 1) / WAITC) : first + 16'((k - 1) / WAITC);
        check(rom_addr_o == ea, dir ? "R2 address" : "R1 address", rom_addr_o, ea);
        if (flip) check(rom_addr_o == ea, "R11 dir ignored mid-load", rom_addr_o, ea);
        check(rom_rd_o && rom_addr_oe_o, "R5 read enable held", rom_rd_o, 1);
        check(!hold_lo_n_o, "R3 low hold asserted", hold_lo_n_o, 0);
        check(hold_hi_o, "R4 high hold asserted", hold_hi_o, 1);
      end
      if (k > 1 && (k - 1) % WAITC == 0 && (k - 1) / WAITC <= TOTAL) begin
        int j;
        logic [15:0] ba;
        j  = (k - 1) / WAITC;
        ba = dir ? first - 16'(j - 1) : first + 16'(j - 1);
        check(byte_valid_o, "R5 valid pulse", byte_valid_o, 1);
        check(byte_o == rom_f(ba), "R5 byte data", byte_o, rom_f(ba));
        check(byte_cnt_o == CNT_W'(j), "R6 byte count", byte_cnt_o, j);
      end else begin
        check(!byte_valid_o, "R5 no valid between captures", byte_valid_o, 0);
      end
      if (k > LOADC && k <= LOADC + TAIL) begin
        check(!rom_rd_o && !rom_addr_oe_o, "R8 quiet in tail", rom_rd_o, 0);
        check(hold_hi_o && !hold_lo_n_o, "R3 R4 holds in tail", hold_hi_o, 1);
        check(!done_o, "R7 done low in tail", done_o, 0);
      end
      if (tail_clk_o) tail_seen++;
      if (k > LOADC + TAIL) begin
        check(done_o, "R7 done after tail", done_o, 1);
        check(hold_lo_n_o && !hold_hi_o, "R3 R4 released at done", hold_hi_o, 0);
        check(!rom_rd_o && !rom_addr_oe_o, "R8 quiet at done", rom_addr_oe_o, 0);
        check(byte_cnt_o == CNT_W'(TOTAL), "R6 final count", byte_cnt_o, TOTAL);
      end
    end
    check(tail_seen == TAIL && TAIL >= 12, "R7 tail clock count", tail_seen, TAIL);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(hold_lo_n_o && !hold_hi_o, "R10 holds released", hold_hi_o, 0);
    check(!done_o && !rom_rd_o && !rom_addr_oe_o, "R10 idle outputs", done_o, 0);
    check(byte_cnt_o == '0, "R10 count zero", byte_cnt_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!rom_rd_o && !rom_addr_oe_o && hold_lo_n_o, "R8 idle quiet", rom_rd_o, 0);

    for (int v = 0; v < 4; v++) begin
      run_load(VEC[v][17], VEC[v][16], VEC[v][15:0]);
    end

    // R9 restart in the middle of a descending load
    pulse_start(1'b1);
    repeat (10) @(negedge clk);
    pulse_start(1'b0);
    check(rom_addr_o == 16'h0000, "R9 restart address", rom_addr_o, 0);
    check(byte_cnt_o == '0, "R9 restart count", byte_cnt_o, 0);
    check(hold_hi_o && !hold_lo_n_o && !done_o, "R9 holds on restart", hold_hi_o, 1);
    // R9 restart during tail
    repeat (LOADC + 2) @(negedge clk);
    check(tail_clk_o, "R7 in tail before restart", tail_clk_o, 1);
    pulse_start(1'b1);
    check(rom_addr_o == 16'hFFFF && rom_rd_o, "R9 restart from tail", rom_addr_o, 16'hFFFF);
    check(!tail_clk_o && byte_cnt_o == '0, "R9 tail cleared", tail_clk_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule